// File: doc/BRIEF.md
# Event time-tagging core

The block keeps a two-level time of day on the system clock: a coarse tick count that runs through one second's worth of clock ticks, and a seconds count that advances each time the tick count rolls over. Four single-cycle event inputs (trigger, acquisition start, acquisition stop and acquisition end) each freeze a copy of the current seconds and tick values. Each channel also counts how many times its event has fired since reset.

Software reaches the block through a 32-bit Wishbone classic slave with a 5-bit word address. It can read the running time and every latched tag. It can also preset the running seconds or tick counter with a write, using byte lanes. All tag words are read-only. Each channel shows four words: occurrence count, seconds, ticks and a sub-tick word. The sub-tick word is always zero because no interpolator is present.

Top module: `evtag_core`

## Requirements
- R1: The coarse counter steps by one on every clock while it is below TICKS_PER_SEC-1. On the clock after it holds TICKS_PER_SEC-1 or more, it returns to 0.
- R2: The seconds counter increments on exactly the clock where the coarse counter returns to 0, and holds otherwise.
- R3: On a clock where bit c of evt_pulse_i is high (bit 0 trigger, 1 acquisition start, 2 acquisition stop, 3 acquisition end), channel c stores the seconds and coarse values held just before that clock edge. Channels are independent, may fire together and may fire on consecutive clocks.
- R4: The count word of channel c holds the number of clocks on which bit c was high since reset.
- R5: The sub-tick word of every channel reads 0.
- R6: Word map on bus_adr_i (byte address bits 6:2): 0 running seconds, 1 running coarse. Channel c occupies words 2+4c (count), 3+4c (seconds), 4+4c (coarse) and 5+4c (sub-tick). Words 18 to 31 read 0.
- R7: A write to word 0 or 1 loads that counter on the clock edge where the request is accepted. Byte b (bits 8b+7:8b) takes bus_dat_i when bus_sel_i[b] is 1 and keeps its old value otherwise. The load overrides that counter's own step or wrap. The other counter is unaffected, and in particular seconds still carries when the old coarse value was terminal.
- R8: Writes to any word other than 0 and 1 change nothing.
- R9: bus_ack_o rises on the clock after bus_cyc_i and bus_stb_i are both seen high and stays high for one clock. Read data appears with that acknowledge and reflects the state before that clock edge. bus_err_o, bus_rty_o and bus_stall_o stay 0.
- R10: After reset, both counters, all tags and all counts are 0 and bus_ack_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| evt_pulse_i | input | N_EVT | Event pulses, one bit per channel |
| bus_adr_i | input | ADR_W | Word address |
| bus_dat_i | input | DATA_W | Write data |
| bus_dat_o | output | DATA_W | Read data |
| bus_sel_i | input | DATA_W/8 | Byte lane enables |
| bus_cyc_i | input | 1 | Bus cycle |
| bus_stb_i | input | 1 | Strobe |
| bus_we_i | input | 1 | Write enable |
| bus_ack_o | output | 1 | Acknowledge |
| bus_err_o | output | 1 | Error, held 0 |
| bus_rty_o | output | 1 | Retry, held 0 |
| bus_stall_o | output | 1 | Stall, held 0 |

## Verification
The bench runs with ten ticks per second. It reads the running time after idle gaps of varying length, so that successive samples land on every tick phase and cross several rollovers. This separates a wrong wrap point from a missed seconds carry. Events are applied singly on each channel, on all four at once, as a three-clock train, and on the terminal tick. These patterns distinguish channel cross-talk, off-by-one capture timing and count errors. Writes are applied with full and partial byte lanes, on the terminal tick, and to tag and unused words, which separates load priority from carry and checks that the read-only words really ignore writes.

// File: rtl/evtag_pkg.sv
package evtag_pkg;

   localparam int unsigned EVT_CHANNELS = 4;
   localparam int unsigned W_SECONDS    = 0;
   localparam int unsigned W_COARSE     = 1;
   localparam int unsigned W_TAG_BASE   = 2;
   localparam int unsigned TAG_WORDS    = 4;

   typedef enum logic [1:0] {
      SLOT_COUNT  = 2'd0,
      SLOT_SEC    = 2'd1,
      SLOT_COARSE = 2'd2,
      SLOT_SUB    = 2'd3
   } tag_slot_e;

   function automatic int unsigned tag_word(input int unsigned ch, input tag_slot_e slot);
      return W_TAG_BASE + TAG_WORDS * ch + int'(slot);
   endfunction

endpackage

// File: rtl/evtag_clock.sv
module evtag_clock #(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned TICKS_PER_SEC = 125_000_000
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              ld_sec_i,
   input  logic              ld_coarse_i,
   input  logic [DATA_W-1:0] ld_value_i,
   output logic [DATA_W-1:0] sec_o,
   output logic [DATA_W-1:0] coarse_o
);
   localparam logic [DATA_W-1:0] LAST_TICK = DATA_W'(TICKS_PER_SEC - 1);

   logic [DATA_W-1:0] sec_q;
   logic [DATA_W-1:0] coarse_q;
   logic              carry;

   // a preset above the terminal value still rolls over on the next clock
   assign carry = (coarse_q >= LAST_TICK);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         coarse_q <= '0;
      end else if (ld_coarse_i) begin
         coarse_q <= ld_value_i;
      end else if (carry) begin
         coarse_q <= '0;
      end else begin
         coarse_q <= coarse_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         sec_q <= '0;
      end else if (ld_sec_i) begin
         sec_q <= ld_value_i;
      end else if (carry) begin
         sec_q <= sec_q + 1'b1;
      end
   end

   assign sec_o    = sec_q;
   assign coarse_o = coarse_q;
endmodule

// File: rtl/evtag_capture.sv
module evtag_capture #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              pulse_i,
   input  logic [DATA_W-1:0] sec_i,
   input  logic [DATA_W-1:0] coarse_i,
   output logic [DATA_W-1:0] count_o,
   output logic [DATA_W-1:0] sec_o,
   output logic [DATA_W-1:0] coarse_o
);
   logic [DATA_W-1:0] count_q;
   logic [DATA_W-1:0] sec_q;
   logic [DATA_W-1:0] coarse_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         count_q  <= '0;
         sec_q    <= '0;
         coarse_q <= '0;
      end else if (pulse_i) begin
         count_q  <= count_q + 1'b1;
         sec_q    <= sec_i;
         coarse_q <= coarse_i;
      end
   end

   assign count_o  = count_q;
   assign sec_o    = sec_q;
   assign coarse_o = coarse_q;
endmodule

// File: rtl/evtag_bus.sv
module evtag_bus
   import evtag_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADR_W  = 5,
   parameter int unsigned N_EVT  = 4
) (
   input  logic                          clk_i,
   input  logic                          rst_n_i,
   input  logic [ADR_W-1:0]              adr_i,
   input  logic [DATA_W-1:0]             dat_i,
   input  logic [DATA_W/8-1:0]           sel_i,
   input  logic                          cyc_i,
   input  logic                          stb_i,
   input  logic                          we_i,
   input  logic [DATA_W-1:0]             live_sec_i,
   input  logic [DATA_W-1:0]             live_coarse_i,
   input  logic [N_EVT-1:0][DATA_W-1:0]  tag_cnt_i,
   input  logic [N_EVT-1:0][DATA_W-1:0]  tag_sec_i,
   input  logic [N_EVT-1:0][DATA_W-1:0]  tag_coarse_i,
   output logic                          ack_o,
   output logic [DATA_W-1:0]             dat_o,
   output logic                          ld_sec_o,
   output logic                          ld_coarse_o,
   output logic [DATA_W-1:0]             wr_word_o
);
   localparam int unsigned BYTES = DATA_W / 8;

   logic              ack_q;
   logic [DATA_W-1:0] dat_q;
   logic              accept;
   logic              hit_sec;
   logic              hit_coarse;
   logic [DATA_W-1:0] cur_word;
   logic [DATA_W-1:0] rd_word;

   assign accept     = cyc_i & stb_i & ~ack_q;
   assign hit_sec    = (adr_i == ADR_W'(W_SECONDS));
   assign hit_coarse = (adr_i == ADR_W'(W_COARSE));
   assign cur_word   = hit_sec ? live_sec_i : live_coarse_i;

   // byte-lane merge with the live value
   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign wr_word_o[8*b +: 8] = sel_i[b] ? dat_i[8*b +: 8] : cur_word[8*b +: 8];
   end

   assign ld_sec_o    = accept & we_i & hit_sec;
   assign ld_coarse_o = accept & we_i & hit_coarse;

   always_comb begin
      rd_word = '0;
      if (hit_sec) begin
         rd_word = live_sec_i;
      end else if (hit_coarse) begin
         rd_word = live_coarse_i;
      end
      for (int c = 0; c < N_EVT; c++) begin
         if (adr_i == ADR_W'(tag_word(c, SLOT_COUNT)))  rd_word = tag_cnt_i[c];
         if (adr_i == ADR_W'(tag_word(c, SLOT_SEC)))    rd_word = tag_sec_i[c];
         if (adr_i == ADR_W'(tag_word(c, SLOT_COARSE))) rd_word = tag_coarse_i[c];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         ack_q <= 1'b0;
         dat_q <= '0;
      end else begin
         ack_q <= accept;
         dat_q <= (accept & ~we_i) ? rd_word : '0;
      end
   end

   assign ack_o = ack_q;
   assign dat_o = dat_q;
endmodule

// File: rtl/evtag_core.sv
module evtag_core
   import evtag_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned ADR_W         = 5,
   parameter int unsigned N_EVT         = EVT_CHANNELS,
   parameter int unsigned TICKS_PER_SEC = 125_000_000
) (
   input  logic                clk_i,
   input  logic                rst_n_i,
   input  logic [N_EVT-1:0]    evt_pulse_i,
   input  logic [ADR_W-1:0]    bus_adr_i,
   input  logic [DATA_W-1:0]   bus_dat_i,
   output logic [DATA_W-1:0]   bus_dat_o,
   input  logic [DATA_W/8-1:0] bus_sel_i,
   input  logic                bus_cyc_i,
   input  logic                bus_stb_i,
   input  logic                bus_we_i,
   output logic                bus_ack_o,
   output logic                bus_err_o,
   output logic                bus_rty_o,
   output logic                bus_stall_o
);
   localparam int unsigned MAP_WORDS = W_TAG_BASE + TAG_WORDS * N_EVT;

   if (TICKS_PER_SEC < 2) begin : g_bad_ticks
      $error("TICKS_PER_SEC must be at least 2");
   end
   if ((DATA_W % 8) != 0 || DATA_W < $clog2(TICKS_PER_SEC)) begin : g_bad_width
      $error("DATA_W must be whole bytes and hold a full second of ticks");
   end
   if (MAP_WORDS > (1 << ADR_W)) begin : g_bad_map
      $error("ADR_W too small for the tag map");
   end

   logic [DATA_W-1:0]             live_sec;
   logic [DATA_W-1:0]             live_coarse;
   logic                          ld_sec;
   logic                          ld_coarse;
   logic [DATA_W-1:0]             wr_word;
   logic [N_EVT-1:0][DATA_W-1:0]  tag_cnt;
   logic [N_EVT-1:0][DATA_W-1:0]  tag_sec;
   logic [N_EVT-1:0][DATA_W-1:0]  tag_coarse;

   evtag_clock #(
      .DATA_W        (DATA_W),
      .TICKS_PER_SEC (TICKS_PER_SEC)
   ) u_clock (
      .clk_i       (clk_i),
      .rst_n_i     (rst_n_i),
      .ld_sec_i    (ld_sec),
      .ld_coarse_i (ld_coarse),
      .ld_value_i  (wr_word),
      .sec_o       (live_sec),
      .coarse_o    (live_coarse)
   );

   for (genvar c = 0; c < N_EVT; c++) begin : g_chan
      evtag_capture #(
         .DATA_W (DATA_W)
      ) u_cap (
         .clk_i    (clk_i),
         .rst_n_i  (rst_n_i),
         .pulse_i  (evt_pulse_i[c]),
         .sec_i    (live_sec),
         .coarse_i (live_coarse),
         .count_o  (tag_cnt[c]),
         .sec_o    (tag_sec[c]),
         .coarse_o (tag_coarse[c])
      );
   end

   evtag_bus #(
      .DATA_W (DATA_W),
      .ADR_W  (ADR_W),
      .N_EVT  (N_EVT)
   ) u_bus (
      .clk_i         (clk_i),
      .rst_n_i       (rst_n_i),
      .adr_i         (bus_adr_i),
      .dat_i         (bus_dat_i),
      .sel_i         (bus_sel_i),
      .cyc_i         (bus_cyc_i),
      .stb_i         (bus_stb_i),
      .we_i          (bus_we_i),
      .live_sec_i    (live_sec),
      .live_coarse_i (live_coarse),
      .tag_cnt_i     (tag_cnt),
      .tag_sec_i     (tag_sec),
      .tag_coarse_i  (tag_coarse),
      .ack_o         (bus_ack_o),
      .dat_o         (bus_dat_o),
      .ld_sec_o      (ld_sec),
      .ld_coarse_o   (ld_coarse),
      .wr_word_o     (wr_word)
   );

   assign bus_err_o   = 1'b0;
   assign bus_rty_o   = 1'b0;
   assign bus_stall_o = 1'b0;
endmodule

// File: rtl/evtag_checker.sv
module evtag_checker #(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned N_EVT         = 4,
   parameter int unsigned TICKS_PER_SEC = 125_000_000
) (
   input logic                         clk_i,
   input logic                         rst_n_i,
   input logic [N_EVT-1:0]             evt_pulse_i,
   input logic                         cyc_i,
   input logic                         stb_i,
   input logic                         ack_i,
   input logic                         ld_sec_i,
   input logic                         ld_coarse_i,
   input logic [DATA_W-1:0]            wr_word_i,
   input logic [DATA_W-1:0]            sec_i,
   input logic [DATA_W-1:0]            coarse_i,
   input logic [N_EVT-1:0][DATA_W-1:0] tag_cnt_i,
   input logic [N_EVT-1:0][DATA_W-1:0] tag_sec_i,
   input logic [N_EVT-1:0][DATA_W-1:0] tag_coarse_i
);
   localparam logic [DATA_W-1:0] LAST_TICK = DATA_W'(TICKS_PER_SEC - 1);

   p_coarse_step_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!ld_coarse_i && coarse_i < LAST_TICK) |=> coarse_i == $past(coarse_i) + 1'b1);

   p_coarse_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!ld_coarse_i && coarse_i >= LAST_TICK) |=> coarse_i == '0);

   p_sec_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!ld_sec_i && coarse_i >= LAST_TICK) |=> sec_i == $past(sec_i) + 1'b1);

   p_sec_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!ld_sec_i && coarse_i < LAST_TICK) |=> $stable(sec_i));

   p_sec_load_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ld_sec_i |=> sec_i == $past(wr_word_i));

   p_coarse_load_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ld_coarse_i |=> coarse_i == $past(wr_word_i));

   for (genvar c = 0; c < N_EVT; c++) begin : g_chk
      p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         evt_pulse_i[c] |=> (tag_sec_i[c] == $past(sec_i)) && (tag_coarse_i[c] == $past(coarse_i)));
      p_count_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         evt_pulse_i[c] |=> tag_cnt_i[c] == $past(tag_cnt_i[c]) + 1'b1);
      p_tag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         !evt_pulse_i[c] |=> $stable(tag_cnt_i[c]) && $stable(tag_sec_i[c]) && $stable(tag_coarse_i[c]));
   end

   p_ack_single_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ack_i |=> !ack_i);

   p_ack_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ack_i |-> $past(cyc_i && stb_i));
endmodule

bind evtag_core evtag_checker #(
   .DATA_W        (DATA_W),
   .N_EVT         (N_EVT),
   .TICKS_PER_SEC (TICKS_PER_SEC)
) u_chk (
   .clk_i        (clk_i),
   .rst_n_i      (rst_n_i),
   .evt_pulse_i  (evt_pulse_i),
   .cyc_i        (bus_cyc_i),
   .stb_i        (bus_stb_i),
   .ack_i        (bus_ack_o),
   .ld_sec_i     (ld_sec),
   .ld_coarse_i  (ld_coarse),
   .wr_word_i    (wr_word),
   .sec_i        (live_sec),
   .coarse_i     (live_coarse),
   .tag_cnt_i    (tag_cnt),
   .tag_sec_i    (tag_sec),
   .tag_coarse_i (tag_coarse)
);

// File: tb/sim_evtag_core.sv
module sim_evtag_core;
   localparam int unsigned T  = 10;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 5;
   localparam int unsigned NE = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NE-1:0]   evt = '0;
   logic [AW-1:0]   adr = '0;
   logic [DW-1:0]   wdat = '0;
   logic [DW-1:0]   rdat;
   logic [DW/8-1:0] sel = '0;
   logic            cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic            ack, err, rty, stall;

   int vectors = 0;
   int misses  = 0;

   always #5 clk = ~clk;

   evtag_core #(
      .DATA_W (DW), .ADR_W (AW), .N_EVT (NE), .TICKS_PER_SEC (T)
   ) u0 (
      .clk_i (clk), .rst_n_i (rst_n), .evt_pulse_i (evt),
      .bus_adr_i (adr), .bus_dat_i (wdat), .bus_dat_o (rdat), .bus_sel_i (sel),
      .bus_cyc_i (cyc), .bus_stb_i (stb), .bus_we_i (we), .bus_ack_o (ack),
      .bus_err_o (err), .bus_rty_o (rty), .bus_stall_o (stall)
   );

   // expected time computed from R1, R2 and R7
   logic [DW-1:0] msec = '0, mcoarse = '0, m_val = '0;
   logic          m_lds = 1'b0, m_ldc = 1'b0;
   always @(posedge clk) begin
      if (!rst_n) begin
         msec    <= '0;
         mcoarse <= '0;
      end else begin
         msec    <= m_lds ? m_val : ((mcoarse >= T - 1) ? msec + 1 : msec);
         mcoarse <= m_ldc ? m_val : ((mcoarse >= T - 1) ? '0 : mcoarse + 1);
      end
   end

   logic [DW-1:0] e_cnt [NE];
   logic [DW-1:0] e_sec [NE];
   logic [DW-1:0] e_crs [NE];

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d,
                         output logic [DW-1:0] s_sec, output logic [DW-1:0] s_crs);
      @(negedge clk);
      adr = a; cyc = 1'b1; stb = 1'b1; we = 1'b0;
      s_sec = msec; s_crs = mcoarse;
      @(negedge clk);
      check("R9 ack on read", {31'd0, ack}, 32'd1);
      d = rdat;
      cyc = 1'b0; stb = 1'b0;
      @(negedge clk);
      check("R9 ack single", {31'd0, ack}, 32'd0);
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [DW/8-1:0] s);
      logic [DW-1:0] cur;
      @(negedge clk);
      adr = a; wdat = d; sel = s; cyc = 1'b1; stb = 1'b1; we = 1'b1;
      cur = (a == 0) ? msec : mcoarse;
      for (int b = 0; b < DW / 8; b++) m_val[8*b +: 8] = s[b] ? d[8*b +: 8] : cur[8*b +: 8];
      m_lds = (a == 0);
      m_ldc = (a == 1);
      @(negedge clk);
      check("R9 ack on write", {31'd0, ack}, 32'd1);
      cyc = 1'b0; stb = 1'b0; we = 1'b0; m_lds = 1'b0; m_ldc = 1'b0;
   endtask

   task automatic fire(input logic [NE-1:0] mask, input int n);
      @(negedge clk);
      evt = mask;
      for (int k = 0; k < n; k++) begin
         for (int c = 0; c < NE; c++) begin
            if (mask[c]) begin
               e_sec[c] = msec; e_crs[c] = mcoarse; e_cnt[c] = e_cnt[c] + 1;
            end
         end
         @(negedge clk);
      end
      evt = '0;
   endtask

   task automatic check_tags(input string tagname);
      logic [DW-1:0] d, s0, s1;
      for (int c = 0; c < NE; c++) begin
         bus_rd(AW'(2 + 4*c), d, s0, s1); check({tagname, " R4 count"}, d, e_cnt[c]);
         bus_rd(AW'(3 + 4*c), d, s0, s1); check({tagname, " R3 seconds"}, d, e_sec[c]);
         bus_rd(AW'(4 + 4*c), d, s0, s1); check({tagname, " R3 coarse"}, d, e_crs[c]);
         bus_rd(AW'(5 + 4*c), d, s0, s1); check({tagname, " R5 sub-tick"}, d, '0);
      end
   endtask

   task automatic check_live(input string tagname);
      logic [DW-1:0] d, s0, s1;
      bus_rd(AW'(1), d, s0, s1); check({tagname, " R1 coarse"}, d, s1);
      bus_rd(AW'(0), d, s0, s1); check({tagname, " R2 seconds"}, d, s0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      logic [DW-1:0] d, s0, s1;
      for (int c = 0; c < NE; c++) begin e_cnt[c] = '0; e_sec[c] = '0; e_crs[c] = '0; end
      repeat (3) @(negedge clk);
      check("R10 ack in reset", {31'd0, ack}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 ack after reset", {31'd0, ack}, 32'd0);
      check("R9 err/rty/stall", {29'd0, err, rty, stall}, 32'd0);
      check_tags("R10 reset");
      check_live("R10 reset");

      // R1 R2: sampled at every phase across several rollovers
      for (int i = 0; i < 30; i++) begin
         repeat (i % 7) @(negedge clk);
         check_live("sweep");
      end

      // R6: unused words
      for (int a = 18; a < 32; a++) begin
         bus_rd(AW'(a), d, s0, s1); check("R6 unused word", d, '0);
      end

      // R3 R4 R5: single events per channel, then all together, then a train
      for (int c = 0; c < NE; c++) begin
         repeat (c * 3 + 1) @(negedge clk);
         fire(NE'(1 << c), 1);
      end
      check_tags("single");
      fire('1, 1);
      check_tags("simultaneous");
      fire(4'b0100, 3);
      check_tags("train");
      while (mcoarse != T - 2) @(negedge clk);
      fire(4'b0001, 1);
      check("R3 capture on terminal tick", e_crs[0], T - 1);
      check_tags("terminal");

      // R7: full and partial loads
      bus_wr(0, 32'h1234_5678, 4'hF);
      bus_rd(0, d, s0, s1); check("R7 seconds load", d, s0);
      check("R7 seconds value", s0, 32'h1234_5678);
      bus_wr(0, 32'hAABB_CCDD, 4'b0101);
      bus_rd(0, d, s0, s1); check("R7 byte lanes", d, 32'h12BB_56DD);
      bus_wr(1, T - 1, 4'hF);
      check_live("R7 R2 load terminal");
      while (mcoarse != T - 2) @(negedge clk);
      bus_wr(1, 32'd5, 4'hF);
      check_live("R7 coarse load over wrap");
      while (mcoarse != T - 2) @(negedge clk);
      bus_wr(0, 32'h0000_0100, 4'hF);
      bus_rd(0, d, s0, s1); check("R7 seconds load beats carry", d, 32'h0000_0100);
      bus_wr(1, 32'd3, 4'h0);
      check_live("R7 no lanes");

      // R8: writes to tag and unused words
      for (int a = 2; a < 32; a++) bus_wr(AW'(a), 32'hFFFF_FFFF, 4'hF);
      check_tags("R8 read-only");
      check_live("R8 live untouched");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule